// File: doc/BRIEF.md
# Packed Signed Saturating Subtractor

This block subtracts one packed operand from another, lane by lane, treating every lane as a two's-complement signed integer and clamping any lane whose true difference will not fit. The lane width is selected at run time by a 2-bit size code: 8, 16, 32 or 64 bits. In vector mode a width bit selects a 64-bit or a 128-bit active span, which is filled with as many lanes as fit. In scalar mode only the lowest lane is processed. Bits above the active span are returned as zero.

A request is presented with `in_valid` for one cycle, and the registered result appears on the next cycle with `out_valid`. One control combination, vector mode with 64-bit lanes in a 64-bit span, has no meaning. The block flags it on `out_undef` and leaves the result and the saturation flag as they were. The sticky flag `sat_flag` collects saturation from every processed lane across any number of requests. Only reset or the `sat_clear` input can clear it.

A small control machine has three states. `ST_IDLE` means no result is being presented. `ST_DONE` means a legal request was accepted on the previous edge. `ST_FAULT` means the previous edge accepted a meaningless encoding. A strobe with a legal encoding moves the machine from any state to `ST_DONE`. A strobe with the illegal encoding moves it from any state to `ST_FAULT`. Without a strobe, the machine returns from any state to `ST_IDLE`.

Top module: `simd_sqsub`

## Requirements
- R1: The lane width is 8 << `lane_size`: code 0 gives 8-bit lanes, code 1 gives 16-bit lanes, code 2 gives 32-bit lanes and code 3 gives 64-bit lanes. Lane k occupies bits [k*W +: W] of each operand and of the result.
- R2: When `scalar`=0, the active span is bits [63:0] if `wide`=0 and bits [127:0] if `wide`=1. Every lane inside the active span is processed.
- R3: When `scalar`=0, `lane_size`=3 and `wide`=0, an accepted strobe gives `out_undef`=1 on the next cycle. The result register is unchanged, and the saturation flag is not set. For every other encoding, `out_undef`=0.
- R4: When `scalar`=1, only lane 0 is processed, the active span equals the lane width, and `wide` has no effect.
- R5: Each processed lane returns opa-lane minus opb-lane, both read as signed values, whenever the true difference is representable.
- R6: A true difference above the lane's largest signed value returns that largest value. A true difference below the lane's smallest signed value returns that smallest value.
- R7: `sat_flag` becomes 1 after an accepted legal request in which any processed lane saturated. Lanes outside the active span never set it. The flag stays at 1 until it is cleared.
- R8: Result bits above the active span read as zero after a legal request.
- R9: `sat_clear` clears `sat_flag` on the next edge. If a clear and a set arrive on the same edge, the flag ends up set.
- R10: A result appears exactly one cycle after its strobe, with `out_valid`=1. Without a strobe, `out_valid` is 0 on the next cycle and the result holds its value.
- R11: After reset, `out_valid`, `out_undef`, `sat_flag` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| opa | input | 128 | Minuend lanes |
| opb | input | 128 | Subtrahend lanes |
| lane_size | input | 2 | Lane width code (8 << code bits) |
| wide | input | 1 | Vector span select: 0 = 64 bits, 1 = 128 bits |
| scalar | input | 1 | 1 = process only lane 0 |
| sat_clear | input | 1 | Synchronous clear of the sticky flag |
| out_valid | output | 1 | Result presented this cycle |
| out_undef | output | 1 | Previous request used the meaningless encoding |
| result | output | 128 | Registered saturated differences |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
The checker watches the control behaviour on every cycle. It covers the one-cycle valid timing, the hold of the result when no strobe arrives, and the undefined-encoding flag with its freeze of the result and the flag. It also checks the zero upper half in narrow vector mode, the zero upper bits for a scalar byte, the stickiness of the flag, and the effect of a clear. The arithmetic values cannot be checked that way. The exact differences, the clamping at each lane width, and the rule that only processed lanes feed the flag are shown by the bench sweeps, which compare every lane against a wide-integer model. The bench sweeps every byte-operand pair in 16 lanes at once and mixes modes at the larger widths.

// File: rtl/simd_sqsub_pkg.sv
package simd_sqsub_pkg;
    localparam int VEC_W     = 128;
    localparam int BYTE_W    = 8;
    localparam int NBYTES    = VEC_W / BYTE_W;
    localparam int NUM_SIZES = 4;
    localparam int CNT_W     = $clog2(NBYTES + 1);
    localparam int HALF_B    = NBYTES / 2;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } lane_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DONE  = 2'd1,
        ST_FAULT = 2'd2
    } op_state_e;
endpackage

// File: rtl/sqsub_lane.sv
module sqsub_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         sat
);
    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] raw;

    always_comb begin
        raw = a - b;
        // overflow only when signs differ and the wrapped result left the minuend's sign
        sat = (a[W-1] ^ b[W-1]) & (raw[W-1] ^ a[W-1]);
        if (sat) begin
            y = a[W-1] ? NEG_LIM : POS_LIM;
        end else begin
            y = raw;
        end
    end
endmodule

// File: rtl/sqsub_bank.sv
module sqsub_bank #(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 8,
    localparam int LANES = VEC_W / LANE_W
) (
    input  logic [VEC_W-1:0] opa,
    input  logic [VEC_W-1:0] opb,
    output logic [VEC_W-1:0] diff,
    output logic [LANES-1:0] lane_sat
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        sqsub_lane #(.W(LANE_W)) u_lane (
            .a   (opa[k*LANE_W +: LANE_W]),
            .b   (opb[k*LANE_W +: LANE_W]),
            .y   (diff[k*LANE_W +: LANE_W]),
            .sat (lane_sat[k])
        );
    end
endmodule

// File: rtl/sqsub_decode.sv
module sqsub_decode
    import simd_sqsub_pkg::*;
(
    input  logic [1:0]       lane_size,
    input  logic             wide,
    input  logic             scalar,
    output logic             illegal,
    output logic [CNT_W-1:0] act_bytes
);
    lane_size_e sz;

    always_comb begin
        sz      = lane_size_e'(lane_size);
        illegal = !scalar && (sz == SZ_64) && !wide;
        if (scalar) begin
            act_bytes = CNT_W'(1) << lane_size;
        end else if (wide) begin
            act_bytes = CNT_W'(NBYTES);
        end else begin
            act_bytes = CNT_W'(HALF_B);
        end
    end
endmodule

// File: rtl/sqsub_sticky.sv
module sqsub_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_req) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/simd_sqsub.sv
module simd_sqsub
    import simd_sqsub_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] opa,
    input  logic [VEC_W-1:0] opb,
    input  logic [1:0]       lane_size,
    input  logic             wide,
    input  logic             scalar,
    input  logic             sat_clear,
    output logic             out_valid,
    output logic             out_undef,
    output logic [VEC_W-1:0] result,
    output logic             sat_flag
);
    logic             illegal;
    logic [CNT_W-1:0] act_bytes;
    logic [VEC_W-1:0] bank_res [NUM_SIZES];
    logic [NUM_SIZES-1:0] bank_sat;
    logic [VEC_W-1:0] sel_res;
    logic             sel_sat;
    logic [VEC_W-1:0] masked_res;
    logic [VEC_W-1:0] result_q;
    logic             accept;
    op_state_e        state_q, state_d;

    sqsub_decode u_decode (
        .lane_size (lane_size),
        .wide      (wide),
        .scalar    (scalar),
        .illegal   (illegal),
        .act_bytes (act_bytes)
    );

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int LW    = BYTE_W << s;
        localparam int LANES = VEC_W / LW;
        logic [VEC_W-1:0] res_w;
        logic [LANES-1:0] sat_w;
        logic [LANES-1:0] live_w;

        sqsub_bank #(.VEC_W(VEC_W), .LANE_W(LW)) u_bank (
            .opa      (opa),
            .opb      (opb),
            .diff     (res_w),
            .lane_sat (sat_w)
        );

        for (genvar k = 0; k < LANES; k++) begin : g_live
            localparam logic [CNT_W-1:0] LAST_B = CNT_W'((k + 1) * (LW / BYTE_W));
            assign live_w[k] = (LAST_B <= act_bytes);
        end

        assign bank_res[s] = res_w;
        assign bank_sat[s] = |(sat_w & live_w);
    end

    always_comb begin
        sel_res = bank_res[lane_size];
        sel_sat = bank_sat[lane_size];
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_bytemask
        localparam logic [CNT_W-1:0] BIDX = CNT_W'(i);
        assign masked_res[i*BYTE_W +: BYTE_W] =
            (BIDX < act_bytes) ? sel_res[i*BYTE_W +: BYTE_W] : '0;
    end

    assign accept = in_valid && !illegal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (accept) begin
            result_q <= masked_res;
        end
    end

    sqsub_sticky u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (accept && sel_sat),
        .clr_req (sat_clear),
        .flag    (sat_flag)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        if (!in_valid) begin
            state_d = ST_IDLE;
        end else if (illegal) begin
            state_d = ST_FAULT;
        end else begin
            state_d = ST_DONE;
        end
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        out_undef = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin out_valid = 1'b0; out_undef = 1'b0; end
            ST_DONE:  begin out_valid = 1'b1; out_undef = 1'b0; end
            ST_FAULT: begin out_valid = 1'b1; out_undef = 1'b1; end
            default:  begin out_valid = 1'b0; out_undef = 1'b0; end
        endcase
    end

    assign result = result_q;
endmodule

// File: rtl/sqsub_checker.sv
module sqsub_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [1:0]   lane_size,
    input logic         wide,
    input logic         scalar,
    input logic         sat_clear,
    input logic         out_valid,
    input logic         out_undef,
    input logic [127:0] result,
    input logic         sat_flag
);
    logic bad_enc;
    assign bad_enc = !scalar && (lane_size == 2'd3) && !wide;

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    p_undef_flagged_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bad_enc) |=> (out_undef && $stable(result)));

    p_undef_noflag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bad_enc && !sat_clear) |=> $stable(sat_flag));

    p_legal_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !bad_enc) |=> !out_undef);

    p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !scalar && !wide && !bad_enc) |=> (result[127:64] == 64'd0));

    p_scalar_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && scalar && lane_size == 2'd0) |=> (result[127:8] == 120'd0));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !sat_clear) |=> sat_flag);

    p_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_flag) |-> $past(in_valid && !bad_enc));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_clear && !in_valid) |=> !sat_flag);
endmodule

bind simd_sqsub sqsub_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .lane_size (lane_size),
    .wide      (wide),
    .scalar    (scalar),
    .sat_clear (sat_clear),
    .out_valid (out_valid),
    .out_undef (out_undef),
    .result    (result),
    .sat_flag  (sat_flag)
);

// File: tb/simd_sqsub_test.sv
module simd_sqsub_test;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] opa = '0, opb = '0;
    logic [1:0]   lane_size = 2'd0;
    logic         wide = 1'b0, scalar = 1'b0, sat_clear = 1'b0;
    logic         out_valid, out_undef, sat_flag;
    logic [127:0] result;

    int applied = 0;
    int miscompares = 0;
    logic [127:0] exp_res = '0;
    logic         exp_flag = 1'b0;
    logic [63:0]  rs = 64'h9E37_79B9_7F4A_7C15;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_sqsub uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
        .lane_size(lane_size), .wide(wide), .scalar(scalar), .sat_clear(sat_clear),
        .out_valid(out_valid), .out_undef(out_undef), .result(result), .sat_flag(sat_flag)
    );

    function automatic logic [63:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 7);
        rs = rs ^ (rs << 17);
        return rs;
    endfunction

    // wide-integer reference for one request
    function automatic void model(input logic [127:0] a, input logic [127:0] b,
                                  input logic [1:0] sz, input logic w, input logic sc,
                                  output logic [127:0] r, output logic s, output logic und);
        int lw, act, nl;
        und = !sc && sz == 2'd3 && !w;
        lw  = 8 << sz;
        act = sc ? lw : (w ? 128 : 64);
        nl  = act / lw;
        r = '0;
        s = 1'b0;
        for (int k = 0; k < nl; k++) begin
            logic [63:0] ea, eb;
            logic signed [63:0] sa, sb;
            logic signed [64:0] xa, xb, d, mx, mn;
            logic [127:0] lmask;
            ea = 64'(a >> (k*lw));
            eb = 64'(b >> (k*lw));
            sa = $signed(ea << (64-lw)) >>> (64-lw);
            sb = $signed(eb << (64-lw)) >>> (64-lw);
            xa = {sa[63], sa};
            xb = {sb[63], sb};
            d  = xa - xb;
            mx = (65'sd1 <<< (lw-1)) - 65'sd1;
            mn = -mx - 65'sd1;
            if (d > mx) begin d = mx; s = 1'b1; end
            else if (d < mn) begin d = mn; s = 1'b1; end
            lmask = (lw == 64) ? {64'd0, {64{1'b1}}} : ((128'd1 << lw) - 128'd1);
            r = r | ((128'(d[63:0]) & lmask) << (k*lw));
        end
    endfunction

    task automatic apply(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                         input logic w, input logic sc, input logic clr, input string req);
        logic [127:0] r;
        logic s, und;
        model(a, b, sz, w, sc, r, s, und);
        opa = a; opb = b; lane_size = sz; wide = w; scalar = sc;
        sat_clear = clr; in_valid = 1'b1;
        if (!und) exp_res = r;
        exp_flag = (!und && s) | (exp_flag & !clr);
        @(negedge clk);
        in_valid = 1'b0; sat_clear = 1'b0;
        applied++;
        if (out_valid !== 1'b1 || out_undef !== und || result !== exp_res || sat_flag !== exp_flag) begin
            miscompares++;
            $display("FAIL %s: valid=%b undef=%b res=%h flag=%b | exp valid=1 undef=%b res=%h flag=%b",
                     req, out_valid, out_undef, result, sat_flag, und, exp_res, exp_flag);
        end
    endtask

    task automatic idle(input logic clr, input string req);
        sat_clear = clr; in_valid = 1'b0;
        if (clr) exp_flag = 1'b0;
        @(negedge clk);
        sat_clear = 1'b0;
        applied++;
        if (out_valid !== 1'b0 || out_undef !== 1'b0 || result !== exp_res || sat_flag !== exp_flag) begin
            miscompares++;
            $display("FAIL %s: valid=%b undef=%b res=%h flag=%b | exp valid=0 undef=0 res=%h flag=%b",
                     req, out_valid, out_undef, result, sat_flag, exp_res, exp_flag);
        end
    endtask

    function automatic logic [127:0] rep(input logic [63:0] v, input int lw);
        logic [127:0] x = '0;
        for (int k = 0; k < 128/lw; k++) x = x | ((128'(v) & ((lw == 64) ? {64'd0, {64{1'b1}}} : ((128'd1 << lw) - 128'd1))) << (k*lw));
        return x;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL R10: watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        applied++;
        if (out_valid !== 1'b0 || out_undef !== 1'b0 || result !== '0 || sat_flag !== 1'b0) begin
            miscompares++;
            $display("FAIL R11: valid=%b undef=%b res=%h flag=%b | exp all zero",
                     out_valid, out_undef, result, sat_flag);
        end
        rst_n = 1'b1;
        @(negedge clk);
        idle(1'b0, "R11 idle after reset");

        // R5 R6 R1 R2: all byte pairs, 16 lanes each, clear every time so flag mirrors this vector
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j += 2) begin
                logic [127:0] a, b;
                for (int k = 0; k < 16; k++) begin
                    a[k*8 +: 8] = 8'(i + k*37);
                    b[k*8 +: 8] = 8'(j + k*91);
                end
                apply(a, b, 2'd0, 1'b1, 1'b0, 1'b1, "R5 R6 byte sweep");
            end
        end

        // R1 R2 R4 R8: mixed sizes and modes, random operands
        for (int n = 0; n < 12000; n++) begin
            logic [127:0] a, b;
            a = {rnd(), rnd()};
            b = {rnd(), rnd()};
            apply(a, b, 2'(n % 4), 1'((n / 4) % 2), 1'((n / 8) % 2), 1'b1, "R1 R2 R4 R8 mixed");
        end

        // R6 directed clamps at every width
        for (int z = 0; z < 4; z++) begin
            int lw;
            lw = 8 << z;
            apply(rep(64'h7FFF_FFFF_FFFF_FFFF >> (64-lw), lw), rep({64{1'b1}}, lw), 2'(z), 1'b1, 1'b0, 1'b1, "R6 clamp max");
            apply(rep(64'h1 << (lw-1), lw), rep(64'd1, lw), 2'(z), 1'b1, 1'b0, 1'b1, "R6 clamp min");
        end

        // R7 / R9 sticky behaviour
        idle(1'b1, "R9 clear without request");
        apply(rep(64'h10, 8), rep(64'h05, 8), 2'd0, 1'b1, 1'b0, 1'b0, "R5 no saturation");
        apply(rep(64'h80, 8), rep(64'h01, 8), 2'd0, 1'b0, 1'b0, 1'b0, "R7 flag set");
        apply(rep(64'h10, 8), rep(64'h05, 8), 2'd0, 1'b1, 1'b0, 1'b0, "R7 flag sticks");
        idle(1'b0, "R7 flag holds idle");
        apply(rep(64'h80, 8), rep(64'h01, 8), 2'd0, 1'b1, 1'b0, 1'b1, "R9 clear and set gives set");
        apply(rep(64'h10, 8), rep(64'h05, 8), 2'd0, 1'b1, 1'b0, 1'b1, "R9 clear with clean request");
        // R7 saturating lanes only in the inactive upper half
        apply({rep(64'h80, 8)}, {64'h0101_0101_0101_0101, 64'd0}, 2'd0, 1'b0, 1'b0, 1'b0, "R7 inactive lanes ignored");
        // R4 scalar: saturating pairs above lane 0 ignored, wide ignored
        apply({rep(64'h8000, 16)}, {rep(64'h0001, 16)} & ~128'hFFFF, 2'd1, 1'b1, 1'b1, 1'b0, "R4 scalar upper ignored");
        apply({rnd(), rnd()}, {rnd(), rnd()}, 2'd3, 1'b0, 1'b1, 1'b0, "R4 scalar 64-bit legal");

        // R3 undefined encoding
        apply(rep(64'h8000_0000_0000_0000, 64), rep(64'd1, 64), 2'd3, 1'b0, 1'b0, 1'b0, "R3 undef holds");
        apply(rep(64'h8000_0000_0000_0000, 64), rep(64'd1, 64), 2'd3, 1'b0, 1'b0, 1'b1, "R3 undef with clear");
        apply(rep(64'h8000_0000_0000_0000, 64), rep(64'd1, 64), 2'd3, 1'b1, 1'b0, 1'b0, "R3 wide 64-bit legal");

        // R10 hold without strobe
        idle(1'b0, "R10 hold");
        idle(1'b0, "R10 hold again");

        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end
endmodule